// File: doc/BRIEF.md
# Keyed Write-Unlock Gate

This block guards a peripheral's register file against stray software writes. A write to any protected address reaches the downstream register port only after software has first stored a 16-bit unlock key in a dedicated key register. The key does not take effect at once. The gate spends a fixed number of clock cycles arming. It then raises the top bit of a status word that software polls, and software gives up after a bounded number of polls.

An open gate passes exactly one protected write, and only while the peripheral reports that it is ready. After that write the gate locks again, so software repeats the sequence for every protected write: wait for ready, write the key, poll for the enable bit, then write. A protected write that the gate does not pass is dropped and raises a one-cycle blocked indication. Writing any value other than the key to the key register cancels an open or arming gate.

Top module: `unlk_wr_gate`

## Requirements
- R1: While reset is applied, and in the first sampled cycle after it, `unlock_status`, `dn_wr_en` and `wr_blocked` are all zero.
- R2: A write to address 0x3C whose low 16 bits equal 0xA55A arms the gate. Status bit 31 becomes 1 exactly ARM_DELAY (default 3) clock edges after the edge that takes the key write. The upper 16 data bits of the key write are ignored.
- R3: `unlock_status` carries the enable in bit 31 only. Bits 30..0 always read 0.
- R4: A write to address 0x3C whose low 16 bits differ from 0xA55A clears the enable, or cancels arming, on the next edge.
- R5: A write to any address other than 0x3C, taken while bit 31 is set and `dn_ready` is high, appears on `dn_wr_en`/`dn_wr_addr`/`dn_wr_data` one cycle later with the same address and data.
- R6: After one write is accepted, bit 31 is 0 in the cycle that `dn_wr_en` is high. A following protected write is blocked.
- R7: A protected write taken while bit 31 is 0, whether the gate is locked or arming, is dropped. `wr_blocked` is high for exactly one cycle, one cycle later.
- R8: A protected write taken while bit 31 is 1 but `dn_ready` is low is dropped with a `wr_blocked` pulse, and bit 31 stays 1.
- R9: A correct key written while the gate is open keeps it open with no new arming delay. A correct key written during arming restarts the full ARM_DELAY count.
- R10: A key-register write never drives `dn_wr_en` and never pulses `wr_blocked`.
- R11: Asserting `rst_n` low clears bit 31 at once, without waiting for a clock edge. After release, the gate stays locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | 1 | Software write strobe, one write per cycle |
| wr_addr | input | 8 | Software write byte address |
| wr_data | input | 32 | Software write data |
| dn_ready | input | 1 | Peripheral is ready to take a register write |
| dn_wr_en | output | 1 | One-cycle downstream write strobe |
| dn_wr_addr | output | 8 | Downstream write address |
| dn_wr_data | output | 32 | Downstream write data |
| wr_blocked | output | 1 | One-cycle pulse for a dropped protected write |
| unlock_status | output | 32 | Readable unlock word, enable in bit 31 |

## Verification
The bench probes the arming window edge by edge. A gate that opened one cycle early or late would show bit 31 at the wrong vector. A design that did not restart the count on a repeated key would open three edges after the first key instead of the second. Relocking is checked by a second write right after an accepted one: a gate that stayed open would pass it downstream instead of pulsing blocked. Two further cases are covered. With the peripheral not ready, a gate that dropped its enable would make software repeat the whole unlock. With stray upper data bits on the key, or a wrong key during arming, a design that compared the full word, or ignored bad keys, would open when it must not, or stay locked when it must open.

// File: rtl/unlk_pkg.sv
package unlk_pkg;

  // Gate sequencing states
  typedef enum logic [1:0] {
    GATE_LOCKED = 2'd0,
    GATE_ARMING = 2'd1,
    GATE_OPEN   = 2'd2
  } gate_state_e;

  // Default geometry shared by the gate and its checker
  localparam int unsigned DEF_DW        = 32;
  localparam int unsigned DEF_AW        = 8;
  localparam int unsigned DEF_KEY_W     = 16;
  localparam int unsigned DEF_ARM_DELAY = 3;

endpackage

// File: rtl/unlk_key_cmp.sv
module unlk_key_cmp #(
  parameter int unsigned AW      = 8,
  parameter int unsigned KEY_W   = 16,
  parameter logic [AW-1:0]    KEY_OFS = 8'h3C,
  parameter logic [KEY_W-1:0] KEY_VAL = 16'hA55A
) (
  input  logic             wr_valid,
  input  logic [AW-1:0]    wr_addr,
  input  logic [KEY_W-1:0] wr_key_bits,
  output logic             key_hit,
  output logic             key_good,
  output logic             prot_hit
);

  logic addr_is_key;

  always_comb begin
    addr_is_key = (wr_addr == KEY_OFS);
    key_hit     = wr_valid && addr_is_key;
    key_good    = (wr_key_bits == KEY_VAL);
    prot_hit    = wr_valid && !addr_is_key;
  end

endmodule

// File: rtl/unlk_arm_timer.sv
module unlk_arm_timer #(
  parameter int unsigned ARM_DELAY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);

  localparam int unsigned CW = (ARM_DELAY > 1) ? $clog2(ARM_DELAY) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(ARM_DELAY - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) begin
      cnt_d = LOAD_VAL;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
    done = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/unlk_ctrl.sv
module unlk_ctrl
  import unlk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic key_hit,
  input  logic key_good,
  input  logic prot_hit,
  input  logic dn_ready,
  input  logic timer_done,
  output logic timer_load,
  output logic accept,
  output logic reject,
  output logic gate_open
);

  gate_state_e state_q;
  gate_state_e state_d;

  always_comb begin
    state_d    = state_q;
    timer_load = 1'b0;
    accept     = prot_hit && (state_q == GATE_OPEN) && dn_ready;
    reject     = prot_hit && !accept;

    unique case (state_q)
      GATE_LOCKED: begin
        if (key_hit && key_good) begin
          state_d    = GATE_ARMING;
          timer_load = 1'b1;
        end
      end
      GATE_ARMING: begin
        if (key_hit) begin
          if (key_good) begin
            timer_load = 1'b1;
          end else begin
            state_d = GATE_LOCKED;
          end
        end else if (timer_done) begin
          state_d = GATE_OPEN;
        end
      end
      GATE_OPEN: begin
        if (key_hit && !key_good) begin
          state_d = GATE_LOCKED;
        end else if (accept) begin
          state_d = GATE_LOCKED;
        end
      end
      default: begin
        state_d = GATE_LOCKED;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GATE_LOCKED;
    end else begin
      state_q <= state_d;
    end
  end

  assign gate_open = (state_q == GATE_OPEN);

endmodule

// File: rtl/unlk_wr_gate.sv
module unlk_wr_gate
  import unlk_pkg::*;
#(
  parameter int unsigned DW        = DEF_DW,
  parameter int unsigned AW        = DEF_AW,
  parameter int unsigned KEY_W     = DEF_KEY_W,
  parameter int unsigned ARM_DELAY = DEF_ARM_DELAY,
  parameter logic [AW-1:0]    KEY_OFS = 8'h3C,
  parameter logic [KEY_W-1:0] KEY_VAL = 16'hA55A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          dn_ready,
  output logic          dn_wr_en,
  output logic [AW-1:0] dn_wr_addr,
  output logic [DW-1:0] dn_wr_data,
  output logic          wr_blocked,
  output logic [DW-1:0] unlock_status
);

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  // Decode and sequencing
  logic key_hit;
  logic key_good;
  logic prot_hit;
  logic timer_load;
  logic timer_done;
  logic accept;
  logic reject;
  logic gate_open;

  unlk_key_cmp #(
    .AW      (AW),
    .KEY_W   (KEY_W),
    .KEY_OFS (KEY_OFS),
    .KEY_VAL (KEY_VAL)
  ) u_key_cmp (
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_key_bits (wr_data[KEY_W-1:0]),
    .key_hit     (key_hit),
    .key_good    (key_good),
    .prot_hit    (prot_hit)
  );

  unlk_arm_timer #(
    .ARM_DELAY (ARM_DELAY)
  ) u_arm_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (timer_load),
    .done  (timer_done)
  );

  unlk_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .key_hit    (key_hit),
    .key_good   (key_good),
    .prot_hit   (prot_hit),
    .dn_ready   (dn_ready),
    .timer_done (timer_done),
    .timer_load (timer_load),
    .accept     (accept),
    .reject     (reject),
    .gate_open  (gate_open)
  );

  // Registered downstream port and blocked pulse
  logic          dn_en_d;
  logic          blk_d;
  logic          dn_en_q;
  logic          blk_q;
  logic [AW-1:0] dn_addr_q;
  logic [DW-1:0] dn_data_q;

  always_comb begin
    dn_en_d = accept;
    blk_d   = reject;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dn_en_q <= 1'b0;
      blk_q   <= 1'b0;
    end else begin
      dn_en_q <= dn_en_d;
      blk_q   <= blk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dn_addr_q <= '0;
      dn_data_q <= '0;
    end else if (accept) begin
      dn_addr_q <= wr_addr;
      dn_data_q <= wr_data;
    end
  end

  assign dn_wr_en      = dn_en_q;
  assign dn_wr_addr    = dn_addr_q;
  assign dn_wr_data    = dn_data_q;
  assign wr_blocked    = blk_q;
  assign unlock_status = {gate_open, {(DW-1){1'b0}}};

endmodule

// File: rtl/unlk_wr_gate_chk.sv
module unlk_wr_gate_chk #(
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 8,
  parameter int unsigned KEY_W = 16,
  parameter logic [AW-1:0]    KEY_OFS = 8'h3C,
  parameter logic [KEY_W-1:0] KEY_VAL = 16'hA55A
) (
  input logic          clk,
  input logic          rst_ok,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          dn_ready,
  input logic          dn_wr_en,
  input logic [AW-1:0] dn_wr_addr,
  input logic [DW-1:0] dn_wr_data,
  input logic          wr_blocked,
  input logic [DW-1:0] unlock_status
);

  logic en;
  logic is_key;
  logic is_prot;
  logic key_ok;

  always_comb begin
    en      = unlock_status[DW-1];
    is_key  = wr_valid && (wr_addr == KEY_OFS);
    is_prot = wr_valid && (wr_addr != KEY_OFS);
    key_ok  = (wr_data[KEY_W-1:0] == KEY_VAL);
  end

  // R5
  accept_src_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    dn_wr_en |-> $past(en && dn_ready && is_prot));

  // R5
  accept_data_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    dn_wr_en |-> (dn_wr_data == $past(wr_data)) && (dn_wr_addr == $past(wr_addr)));

  // R6
  relock_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    dn_wr_en |-> !en);

  // R7
  lock_block_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (is_prot && !en) |=> (wr_blocked && !dn_wr_en));

  // R4
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (is_key && !key_ok) |=> !en);

  // R2
  arm_delay_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (is_key && key_ok && !en) |=> !en);

  // R3
  status_bits_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    unlock_status[DW-2:0] == '0);

  // R10
  key_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    is_key |=> (!dn_wr_en && !wr_blocked));

  // R8
  not_ready_keep_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (is_prot && en && !dn_ready) |=> (en && wr_blocked));

endmodule

bind unlk_wr_gate unlk_wr_gate_chk #(
  .DW      (DW),
  .AW      (AW),
  .KEY_W   (KEY_W),
  .KEY_OFS (KEY_OFS),
  .KEY_VAL (KEY_VAL)
) u_chk (
  .clk           (clk),
  .rst_ok        (rst_sync_n),
  .wr_valid      (wr_valid),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .dn_ready      (dn_ready),
  .dn_wr_en      (dn_wr_en),
  .dn_wr_addr    (dn_wr_addr),
  .dn_wr_data    (dn_wr_data),
  .wr_blocked    (wr_blocked),
  .unlock_status (unlock_status)
);

// File: tb/sim_unlk_wr_gate.sv
module sim_unlk_wr_gate;

  localparam int CLK_PERIOD = 10;
  localparam int NV         = 28;

  typedef struct packed {
    logic        v;
    logic [7:0]  a;
    logic [31:0] d;
    logic        r;
    logic        e_dn;
    logic        e_bl;
    logic        e_st;
    logic [3:0]  req;
  } vec_t;

  // v, addr, data, ready, exp dn_wr_en, exp wr_blocked, exp bit31, requirement
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h3C, 32'h0000_A55A, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 key
    '{1'b0, 8'h00, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 4'd2},
    '{1'b0, 8'h00, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 4'd2},
    '{1'b0, 8'h00, 32'h0,         1'b1, 1'b0, 1'b0, 1'b1, 4'd2},  // R2 opens
    '{1'b1, 8'h10, 32'h1111_2222, 1'b1, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 pass
    '{1'b1, 8'h14, 32'h3333_4444, 1'b1, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 relocked
    '{1'b0, 8'h00, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 one cycle
    '{1'b1, 8'h3C, 32'h0000_1234, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 bad key
    '{1'b1, 8'h18, 32'h5555_6666, 1'b1, 1'b0, 1'b1, 1'b0, 4'd7},  // R7 locked
    '{1'b1, 8'h3C, 32'hFFFF_A55A, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 upper ignored
    '{1'b1, 8'h1C, 32'h7777_8888, 1'b1, 1'b0, 1'b1, 1'b0, 4'd7},  // R7 arming
    '{1'b0, 8'h00, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 4'd2},
    '{1'b0, 8'h00, 32'h0,         1'b1, 1'b0, 1'b0, 1'b1, 4'd2},
    '{1'b1, 8'h20, 32'h9999_AAAA, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8},  // R8 not ready
    '{1'b1, 8'h3C, 32'h0000_A55A, 1'b1, 1'b0, 1'b0, 1'b1, 4'd9},  // R9 stays open
    '{1'b1, 8'h3C, 32'h0000_5AA5, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 from open
    '{1'b1, 8'h3C, 32'h0000_A55A, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9},
    '{1'b0, 8'h00, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 4'd9},
    '{1'b1, 8'h3C, 32'h0000_A55A, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 restart
    '{1'b0, 8'h00, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 4'd9},  // old count ends
    '{1'b0, 8'h00, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 4'd9},
    '{1'b0, 8'h00, 32'h0,         1'b1, 1'b0, 1'b0, 1'b1, 4'd9},
    '{1'b1, 8'h24, 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 1'b0, 4'd5},
    '{1'b1, 8'h3C, 32'h0000_A55A, 1'b1, 1'b0, 1'b0, 1'b0, 4'd10}, // R10
    '{1'b1, 8'h3C, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 in arming
    '{1'b0, 8'h00, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 4'd4},
    '{1'b0, 8'h00, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 4'd4},
    '{1'b0, 8'h00, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 4'd4}
  };

  logic        clk;
  logic        rst_n;
  logic        wr_valid;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic        dn_ready;
  logic        dn_wr_en;
  logic [7:0]  dn_wr_addr;
  logic [31:0] dn_wr_data;
  logic        wr_blocked;
  logic [31:0] unlock_status;

  int total;
  int bad;
  bit finished;

  unlk_wr_gate u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_valid      (wr_valid),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .dn_ready      (dn_ready),
    .dn_wr_en      (dn_wr_en),
    .dn_wr_addr    (dn_wr_addr),
    .dn_wr_data    (dn_wr_data),
    .wr_blocked    (wr_blocked),
    .unlock_status (unlock_status)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(input logic v, input logic [7:0] a,
                      input logic [31:0] d, input logic r);
    wr_valid = v;
    wr_addr  = a;
    wr_data  = d;
    dn_ready = r;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    total    = 0;
    bad      = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    wr_valid = 1'b0;
    wr_addr  = '0;
    wr_data  = '0;
    dn_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(1, "status in reset", unlock_status, 32'h0);
    chk(1, "dn_wr_en in reset", {31'b0, dn_wr_en}, 32'h0);
    chk(1, "blocked in reset", {31'b0, wr_blocked}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: first cycles after release
    chk(1, "status after release", unlock_status, 32'h0);
    chk(1, "outputs after release", {30'b0, dn_wr_en, wr_blocked}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].v, VEC[i].a, VEC[i].d, VEC[i].r);
      chk(int'(VEC[i].req), $sformatf("vec %0d dn_wr_en", i), {31'b0, dn_wr_en}, {31'b0, VEC[i].e_dn});
      chk(int'(VEC[i].req), $sformatf("vec %0d blocked", i), {31'b0, wr_blocked}, {31'b0, VEC[i].e_bl});
      chk(int'(VEC[i].req), $sformatf("vec %0d enable", i), {31'b0, unlock_status[31]}, {31'b0, VEC[i].e_st});
      if (VEC[i].e_dn) begin
        // R5: forwarded address and data
        chk(5, $sformatf("vec %0d dn addr", i), {24'b0, dn_wr_addr}, {24'b0, VEC[i].a});
        chk(5, $sformatf("vec %0d dn data", i), dn_wr_data, VEC[i].d);
      end
      // R3: low status bits stay zero
      chk(3, $sformatf("vec %0d low status", i), {1'b0, unlock_status[30:0]}, 32'h0);
    end

    // R2: software-style bounded polling sees the enable on the third poll
    begin
      int polls;
      polls = 0;
      step(1'b1, 8'h3C, 32'h0000_A55A, 1'b1);
      for (int p = 0; p < 8; p++) begin
        step(1'b0, 8'h00, 32'h0, 1'b1);
        polls++;
        if (unlock_status[31]) break;
      end
      chk(2, "polls until enable", polls, 3);
      // R3: whole status word when open
      chk(3, "open status word", unlock_status, 32'h8000_0000);
    end

    // R11: asynchronous reset clears the open gate without a clock edge
    rst_n = 1'b0;
    #1;
    chk(11, "status on async reset", unlock_status, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step(1'b1, 8'h30, 32'h0BAD_0BAD, 1'b1);
    // R11: locked after release, so the write is blocked
    chk(11, "blocked after reset", {30'b0, dn_wr_en, wr_blocked}, 32'h1);

    // R8: repeated not-ready attempts keep the enable until ready
    step(1'b1, 8'h3C, 32'h0000_A55A, 1'b1);
    repeat (3) step(1'b0, 8'h00, 32'h0, 1'b1);
    step(1'b1, 8'h40, 32'h0000_0001, 1'b0);
    step(1'b1, 8'h40, 32'h0000_0002, 1'b0);
    chk(8, "enable kept", {31'b0, unlock_status[31]}, 32'h1);
    step(1'b1, 8'h40, 32'h0000_0003, 1'b1);
    chk(8, "late accept", {31'b0, dn_wr_en}, 32'h1);
    chk(8, "late accept data", dn_wr_data, 32'h0000_0003);

    finish_run();
  end

endmodule